// File: doc/BRIEF.md
# Per-Pixel Calibration Histogram Accumulator

During a calibration scan, charge is injected into every pixel many times for each front-end setting. A decoded hit stream arrives at this block, each hit naming one pixel and carrying a 4-bit time-over-threshold (ToT) value. Each hit is consumed locally. Nothing is forwarded. For every pixel the block keeps three statistics side by side in one on-chip memory word: how often the pixel fired, the sum of its ToT values and the sum of the squared ToT values. An external fit later derives mean and spread from these three numbers.

Each bin is updated by a three-stage read, add and write pipeline, which accepts one hit per clock. Bins in flight are forwarded to the add stage, so hits to the same pixel in consecutive cycles are never lost. Before a scan, a clear command zeroes every bin, one address per cycle. After the scan, a dump command streams all bins out in ascending pixel order over a valid/ready interface to the packet sender. While a clear or dump is running, incoming hits are refused and counted as dropped.

Top module: `calib_hist_acc`

## Requirements
- R1: After reset, busy is 0, hit_ready is 1, out_valid is 0 and drop_count is 0.
- R2: A hit taken on a rising edge with hit_valid and hit_ready both high adds 1 to the pixel's occupancy, hit_tot to its ToT sum and hit_tot squared to its squared sum. hit_ready stays high in every idle cycle, so one hit per cycle can be taken.
- R3: Hits to one pixel in consecutive or nearly consecutive cycles are all counted, with no update lost.
- R4: The occupancy field (10 bits), the ToT sum field (14 bits) and the squared sum field (18 bits) each saturate at all ones, independently of the other two.
- R5: A clear_start pulse in idle first waits for in-flight hits to be written and then zeroes every bin. busy stays high and hit_ready stays low until the clear ends.
- R6: A dump_start pulse in idle waits for in-flight hits to be written. It then presents exactly one word per pixel with out_pixel running 0, 1, ... up to the last pixel, one word per handshake with out_valid and out_ready both high. busy falls after the last handshake.
- R7: While out_valid is high and out_ready is low, out_pixel, out_occ, out_sum and out_sq hold their values.
- R8: A hit with hit_valid high while busy is high leaves every bin unchanged and raises drop_count by 1. drop_count saturates at all ones (8 bits by default) and only reset clears it.
- R9: If clear_start and dump_start are high in the same idle cycle, the clear wins and no word is presented. Commands that arrive while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_valid | input | 1 | A hit is offered |
| hit_ready | output | 1 | The block takes hits (idle) |
| hit_pixel | input | ADDR_W | Pixel address of the hit |
| hit_tot | input | TOT_W | ToT value of the hit |
| clear_start | input | 1 | Pulse to zero all bins |
| dump_start | input | 1 | Pulse to stream all bins out |
| busy | output | 1 | Clear or dump in progress |
| out_valid | output | 1 | Readout word present |
| out_ready | input | 1 | Sender takes the readout word |
| out_pixel | output | ADDR_W | Pixel address of the readout word |
| out_occ | output | OCC_W | Occupancy of that pixel |
| out_sum | output | SUM_W | ToT sum of that pixel |
| out_sq | output | SQ_W | Squared-ToT sum of that pixel |
| drop_count | output | DROP_W | Sticky, saturating count of refused hits |

## Verification
The bench builds the block with ADDR_W set to 5, which gives 32 pixels, and keeps the default field widths and drop counter width. With only 32 pixels, a whole clear or dump sweep takes a few dozen cycles, and random hits that favour a small group of pixels produce frequent same-pixel collisions in the pipeline. Because the field widths are the real ones, a run of 1100 hits to one pixel reaches occupancy and ToT-sum saturation while the squared sum stays below its limit. A long stalled dump drives the 8-bit drop counter to its ceiling.

// File: rtl/calib_hist_pkg.sv
package calib_hist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN_CLR,
        ST_DRAIN_DMP,
        ST_CLEAR,
        ST_DUMP
    } hist_state_e;

endpackage

// File: rtl/hist_ram.sv
module hist_ram #(
    parameter int AW = 12,
    parameter int DW = 42
) (
    input  logic          clk,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          ren,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    // read-before-write on an address collision; the read word holds when ren is low
    always_ff @(posedge clk) begin
        if (wen) mem[waddr] <= wdata;
        if (ren) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/hist_accum.sv
module hist_accum #(
    parameter int AW = 12,
    parameter int TW = 4,
    parameter int OW = 10,
    parameter int SW = 14,
    parameter int QW = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [AW-1:0]       in_addr,
    input  logic [TW-1:0]       in_tot,
    output logic                rd_en,
    output logic [AW-1:0]       rd_addr,
    input  logic [OW+SW+QW-1:0] rd_data,
    output logic                wr_en,
    output logic [AW-1:0]       wr_addr,
    output logic [OW+SW+QW-1:0] wr_data,
    output logic                empty
);
    localparam int BW  = OW + SW + QW;
    localparam int TT  = 2 * TW;
    localparam int OWP = OW + 1;
    localparam int SWP = SW + 1;
    localparam int QWP = QW + 1;

    typedef struct packed {
        logic          s1_v;
        logic [AW-1:0] s1_addr;
        logic [TW-1:0] s1_tot;
        logic          s2_v;
        logic [AW-1:0] s2_addr;
        logic [BW-1:0] s2_bin;
        logic          s3_v;
        logic [AW-1:0] s3_addr;
        logic [BW-1:0] s3_bin;
    } acc_state_t;

    acc_state_t q, d;

    logic [BW-1:0]  base_bin;
    logic [TT-1:0]  tot_sq;
    logic [OWP-1:0] occ_w;
    logic [SWP-1:0] sum_w;
    logic [QWP-1:0] sq_w;
    logic [OW-1:0]  occ_n;
    logic [SW-1:0]  sum_n;
    logic [QW-1:0]  sq_n;

    assign rd_en   = in_valid;
    assign rd_addr = in_addr;
    assign wr_en   = q.s2_v;
    assign wr_addr = q.s2_addr;
    assign wr_data = q.s2_bin;
    assign empty   = !q.s1_v && !q.s2_v && !q.s3_v;

    always_comb begin
        d = q;
        // newest copy of the bin wins: write stage, then last written, then memory
        base_bin = rd_data;
        if (q.s3_v && (q.s3_addr == q.s1_addr)) base_bin = q.s3_bin;
        if (q.s2_v && (q.s2_addr == q.s1_addr)) base_bin = q.s2_bin;

        tot_sq = TT'(q.s1_tot) * TT'(q.s1_tot);
        occ_w  = {1'b0, base_bin[OW-1:0]} + OWP'(1);
        sum_w  = {1'b0, base_bin[OW+SW-1:OW]} + SWP'(q.s1_tot);
        sq_w   = {1'b0, base_bin[BW-1:OW+SW]} + QWP'(tot_sq);
        occ_n  = occ_w[OW] ? '1 : occ_w[OW-1:0];
        sum_n  = sum_w[SW] ? '1 : sum_w[SW-1:0];
        sq_n   = sq_w[QW]  ? '1 : sq_w[QW-1:0];

        d.s1_v    = in_valid;
        d.s1_addr = in_addr;
        d.s1_tot  = in_tot;
        d.s2_v    = q.s1_v;
        d.s2_addr = q.s1_addr;
        d.s2_bin  = {sq_n, sum_n, occ_n};
        d.s3_v    = q.s2_v;
        d.s3_addr = q.s2_addr;
        d.s3_bin  = q.s2_bin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: a hit right behind another to the same pixel builds on its result
    a_r3_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s1_v && q.s2_v && (q.s1_addr == q.s2_addr))
        |=> (q.s2_bin[OW-1:0] == (($past(q.s2_bin[OW-1:0]) == {OW{1'b1}}) ?
                                  {OW{1'b1}} : $past(q.s2_bin[OW-1:0]) + OW'(1))));

    // R4: occupancy never decreases along a same-pixel chain
    a_r4_occ_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (q.s1_v && q.s2_v && (q.s1_addr == q.s2_addr))
        |=> (q.s2_bin[OW-1:0] >= $past(q.s2_bin[OW-1:0])));

endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl
    import calib_hist_pkg::*;
#(
    parameter int AW = 12,
    parameter int EW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_start,
    input  logic          dump_start,
    input  logic          hit_valid,
    input  logic          pipe_empty,
    input  logic          out_ready,
    output logic          busy,
    output logic          clr_wen,
    output logic [AW-1:0] clr_addr,
    output logic          dmp_ren,
    output logic [AW-1:0] dmp_raddr,
    output logic          out_valid,
    output logic [AW-1:0] out_addr,
    output logic [EW-1:0] drop_count
);
    localparam logic [AW-1:0] LAST     = '1;
    localparam logic [EW-1:0] DROP_MAX = '1;

    typedef struct packed {
        hist_state_e   state;
        logic [AW-1:0] ptr;
        logic          out_valid;
        logic [AW-1:0] out_addr;
        logic [EW-1:0] drop;
    } ctrl_state_t;

    ctrl_state_t q, d;

    always_comb begin
        d         = q;
        clr_wen   = 1'b0;
        clr_addr  = q.ptr;
        dmp_ren   = 1'b0;
        dmp_raddr = q.out_addr + AW'(1);

        unique case (q.state)
            ST_IDLE: begin
                if (clear_start)     d.state = ST_DRAIN_CLR;
                else if (dump_start) d.state = ST_DRAIN_DMP;
            end
            ST_DRAIN_CLR: begin
                if (pipe_empty) begin
                    d.state = ST_CLEAR;
                    d.ptr   = '0;
                end
            end
            ST_CLEAR: begin
                clr_wen = 1'b1;
                d.ptr   = q.ptr + AW'(1);
                if (q.ptr == LAST) d.state = ST_IDLE;
            end
            ST_DRAIN_DMP: begin
                if (pipe_empty) begin
                    dmp_ren     = 1'b1;
                    dmp_raddr   = '0;
                    d.out_valid = 1'b1;
                    d.out_addr  = '0;
                    d.state     = ST_DUMP;
                end
            end
            ST_DUMP: begin
                if (q.out_valid && out_ready) begin
                    if (q.out_addr == LAST) begin
                        d.out_valid = 1'b0;
                        d.state     = ST_IDLE;
                    end else begin
                        dmp_ren    = 1'b1;
                        d.out_addr = q.out_addr + AW'(1);
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase

        if (hit_valid && (q.state != ST_IDLE) && (q.drop != DROP_MAX))
            d.drop = q.drop + EW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy       = (q.state != ST_IDLE);
    assign out_valid  = q.out_valid;
    assign out_addr   = q.out_addr;
    assign drop_count = q.drop;

    // R5: the zeroing sweep only begins once the pipeline has drained
    a_r5_clear_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state == ST_CLEAR) && ($past(q.state) == ST_DRAIN_CLR)) |-> $past(pipe_empty));

    // R6: each handshake that is not the last moves on to the next pixel
    a_r6_dump_step: assert property (@(posedge clk) disable iff (!rst_n)
        (q.out_valid && out_ready && (q.out_addr != LAST))
        |=> (q.out_valid && (q.out_addr == $past(q.out_addr) + AW'(1))));

    // R7: a stalled word keeps its address
    a_r7_stall_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (q.out_valid && !out_ready) |=> (q.out_valid && $stable(q.out_addr)));

    // R8: a refused hit bumps the drop counter until it saturates
    a_r8_drop_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && busy && (q.drop != DROP_MAX)) |=> (q.drop == $past(q.drop) + EW'(1)));

    // R8: the drop counter never goes down
    a_r8_drop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (q.drop >= $past(q.drop)));

endmodule

// File: rtl/calib_hist_acc.sv
module calib_hist_acc #(
    parameter int ADDR_W = 12,
    parameter int TOT_W  = 4,
    parameter int OCC_W  = 10,
    parameter int SUM_W  = 14,
    parameter int SQ_W   = 18,
    parameter int DROP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit_valid,
    output logic              hit_ready,
    input  logic [ADDR_W-1:0] hit_pixel,
    input  logic [TOT_W-1:0]  hit_tot,
    input  logic              clear_start,
    input  logic              dump_start,
    output logic              busy,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_pixel,
    output logic [OCC_W-1:0]  out_occ,
    output logic [SUM_W-1:0]  out_sum,
    output logic [SQ_W-1:0]   out_sq,
    output logic [DROP_W-1:0] drop_count
);
    localparam int BW = OCC_W + SUM_W + SQ_W;

    logic              acc_in_valid;
    logic              acc_rd_en, acc_wr_en, pipe_empty;
    logic [ADDR_W-1:0] acc_rd_addr, acc_wr_addr;
    logic [BW-1:0]     acc_wr_data, rd_data;
    logic              clr_wen, dmp_ren;
    logic [ADDR_W-1:0] clr_addr, dmp_raddr;
    logic              ram_wen, ram_ren;
    logic [ADDR_W-1:0] ram_waddr, ram_raddr;
    logic [BW-1:0]     ram_wdata;

    assign hit_ready    = !busy;
    assign acc_in_valid = hit_valid && hit_ready;

    // accumulation and sequencing never need the same port in one cycle
    assign ram_wen   = clr_wen || acc_wr_en;
    assign ram_waddr = clr_wen ? clr_addr : acc_wr_addr;
    assign ram_wdata = clr_wen ? '0 : acc_wr_data;
    assign ram_ren   = dmp_ren || acc_rd_en;
    assign ram_raddr = dmp_ren ? dmp_raddr : acc_rd_addr;

    hist_ram #(.AW(ADDR_W), .DW(BW)) i_ram (
        .clk   (clk),
        .wen   (ram_wen),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .ren   (ram_ren),
        .raddr (ram_raddr),
        .rdata (rd_data)
    );

    hist_accum #(
        .AW(ADDR_W), .TW(TOT_W), .OW(OCC_W), .SW(SUM_W), .QW(SQ_W)
    ) i_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (acc_in_valid),
        .in_addr  (hit_pixel),
        .in_tot   (hit_tot),
        .rd_en    (acc_rd_en),
        .rd_addr  (acc_rd_addr),
        .rd_data  (rd_data),
        .wr_en    (acc_wr_en),
        .wr_addr  (acc_wr_addr),
        .wr_data  (acc_wr_data),
        .empty    (pipe_empty)
    );

    hist_ctrl #(.AW(ADDR_W), .EW(DROP_W)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_start (clear_start),
        .dump_start  (dump_start),
        .hit_valid   (hit_valid),
        .pipe_empty  (pipe_empty),
        .out_ready   (out_ready),
        .busy        (busy),
        .clr_wen     (clr_wen),
        .clr_addr    (clr_addr),
        .dmp_ren     (dmp_ren),
        .dmp_raddr   (dmp_raddr),
        .out_valid   (out_valid),
        .out_addr    (out_pixel),
        .drop_count  (drop_count)
    );

    assign out_occ = rd_data[OCC_W-1:0];
    assign out_sum = rd_data[OCC_W+SUM_W-1:OCC_W];
    assign out_sq  = rd_data[BW-1:OCC_W+SUM_W];

    // R7: a stalled word keeps its statistics
    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(rd_data));

    // R5: nothing is written from the hit path while a clear sweeps memory
    a_r5_no_hit_write_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wen |-> !acc_wr_en);

endmodule

// File: tb/test_calib_hist_acc.sv
module test_calib_hist_acc;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 5;
    localparam int N    = 1 << AW;
    localparam int OMAX = 1023;
    localparam int SMAX = 16383;
    localparam int QMAX = 262143;
    localparam int DMAX = 255;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hit_valid = 1'b0;
    logic hit_ready;
    logic [AW-1:0] hit_pixel = '0;
    logic [3:0] hit_tot = '0;
    logic clear_start = 1'b0;
    logic dump_start = 1'b0;
    logic busy, out_valid;
    logic out_ready = 1'b0;
    logic [AW-1:0] out_pixel;
    logic [9:0] out_occ;
    logic [13:0] out_sum;
    logic [17:0] out_sq;
    logic [7:0] drop_count;

    int checks = 0;
    int fails = 0;
    int exp_occ [N];
    int exp_sum [N];
    int exp_sq  [N];
    int exp_drop = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    calib_hist_acc #(.ADDR_W(AW)) i_calib_hist_acc (
        .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_ready(hit_ready),
        .hit_pixel(hit_pixel), .hit_tot(hit_tot), .clear_start(clear_start),
        .dump_start(dump_start), .busy(busy), .out_valid(out_valid),
        .out_ready(out_ready), .out_pixel(out_pixel), .out_occ(out_occ),
        .out_sum(out_sum), .out_sq(out_sq), .drop_count(drop_count)
    );

    function automatic int sat(input int v, input int mx);
        return (v > mx) ? mx : v;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_zero();
        for (int i = 0; i < N; i++) begin
            exp_occ[i] = 0; exp_sum[i] = 0; exp_sq[i] = 0;
        end
    endtask

    // drive one cycle of hit input; the model follows the handshake the block will see
    task automatic send(input bit v, input int px, input int tot);
        @(negedge clk);
        hit_valid = v;
        hit_pixel = AW'(px);
        hit_tot   = 4'(tot);
        #1;
        if (v) begin
            if (hit_ready) begin
                exp_occ[px] = sat(exp_occ[px] + 1, OMAX);
                exp_sum[px] = sat(exp_sum[px] + tot, SMAX);
                exp_sq[px]  = sat(exp_sq[px] + tot * tot, QMAX);
            end else begin
                exp_drop = sat(exp_drop + 1, DMAX);
            end
        end
    endtask

    task automatic idle_hits();
        @(negedge clk);
        hit_valid = 1'b0;
    endtask

    task automatic wait_not_busy();
        int guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        #1;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clear_start = 1'b1;
        @(negedge clk);
        clear_start = 1'b0;
    endtask

    task automatic run_clear();
        pulse_clear();
        #1;
        check("R5", "busy during clear", int'(busy), 1);
        check("R5", "hit_ready during clear", int'(hit_ready), 0);
        wait_not_busy();
        model_zero();
    endtask

    // collect a full dump; random_ready inserts stalls
    task automatic dump_collect(input string req, input bit random_ready);
        int idx = 0;
        int guard = 0;
        int bad = 0;
        bit stalled = 1'b0;
        int st_px = 0, st_occ = 0, st_sum = 0, st_sq = 0;
        while (idx < N && guard < 4000) begin
            @(negedge clk);
            guard++;
            out_ready = random_ready ? (($urandom % 4) != 0) : 1'b1;
            #1;
            if (stalled && out_valid) begin
                check("R7", "stalled word held",
                      int'(out_pixel == AW'(st_px) && out_occ == 10'(st_occ) &&
                           out_sum == 14'(st_sum) && out_sq == 18'(st_sq)), 1);
            end
            stalled = 1'b0;
            if (out_valid && out_ready) begin
                if (int'(out_pixel) != idx || int'(out_occ) != exp_occ[idx] ||
                    int'(out_sum) != exp_sum[idx] || int'(out_sq) != exp_sq[idx]) begin
                    bad++;
                    $display("FAIL %s pixel %0d: actual px %0d occ %0d sum %0d sq %0d expected px %0d occ %0d sum %0d sq %0d",
                             req, idx, out_pixel, out_occ, out_sum, out_sq,
                             idx, exp_occ[idx], exp_sum[idx], exp_sq[idx]);
                end
                checks++;
                idx++;
            end else if (out_valid) begin
                stalled = 1'b1;
                st_px = int'(out_pixel); st_occ = int'(out_occ);
                st_sum = int'(out_sum); st_sq = int'(out_sq);
            end
        end
        fails += bad;
        check("R6", "words transferred", idx, N);
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        check("R6", "out_valid after last word", int'(out_valid), 0);
        check("R6", "busy after last word", int'(busy), 0);
    endtask

    task automatic run_dump(input string req, input bit random_ready);
        @(negedge clk);
        dump_start = 1'b1;
        @(negedge clk);
        dump_start = 1'b0;
        dump_collect(req, random_ready);
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1", "busy", int'(busy), 0);
        check("R1", "hit_ready", int'(hit_ready), 1);
        check("R1", "out_valid", int'(out_valid), 0);
        check("R1", "drop_count", int'(drop_count), 0);

        run_clear();
        run_dump("R5 zero after clear", 1'b0);

        // R2: random hits favouring a few pixels
        for (int k = 0; k < 600; k++) begin
            int px;
            px = (($urandom % 2) == 0) ? int'($urandom % 4) : int'($urandom % N);
            send(($urandom % 100) < 85, px, int'($urandom % 16));
        end
        idle_hits();
        run_dump("R2 random accumulation", 1'b1);

        // R3: directed same-pixel streams
        run_clear();
        for (int k = 0; k < 10; k++) send(1'b1, 7, 15);
        for (int k = 0; k < 12; k++) send(1'b1, (k % 2 == 0) ? 8 : 9, k);
        for (int k = 0; k < 9; k++) send(1'b1, (k % 3 == 0) ? 10 : 11, 3);
        idle_hits();
        run_dump("R3 back-to-back", 1'b1);

        // R4: saturation of occupancy and ToT sum, squared sum below limit
        run_clear();
        for (int k = 0; k < 1100; k++) send(1'b1, 3, 15);
        for (int k = 0; k < 1030; k++) send(1'b1, 4, 1);
        idle_hits();
        run_dump("R4 saturation", 1'b0);
        check("R4", "occ model ceiling", exp_occ[3], OMAX);
        check("R4", "sum model ceiling", exp_sum[3], SMAX);

        // R8: hits during a clear are dropped and counted
        pulse_clear();
        for (int k = 0; k < 5; k++) send(1'b1, 1, 5);
        idle_hits();
        wait_not_busy();
        model_zero();
        check("R8", "drop_count after clear", int'(drop_count), exp_drop);
        send(1'b1, 2, 6);
        idle_hits();

        // R8: stalled dump, many refused hits saturate the counter, bins untouched
        @(negedge clk);
        dump_start = 1'b1;
        out_ready  = 1'b0;
        @(negedge clk);
        dump_start = 1'b0;
        for (int k = 0; k < 300; k++) send(1'b1, 2, 9);
        idle_hits();
        #1;
        check("R8", "drop_count saturated", int'(drop_count), DMAX);
        dump_collect("R8 dropped hits ignored", 1'b1);

        // R9: clear and dump together, clear wins; dump during busy ignored
        for (int k = 0; k < 20; k++) send(1'b1, k % N, 2);
        idle_hits();
        @(negedge clk);
        clear_start = 1'b1;
        dump_start  = 1'b1;
        @(negedge clk);
        clear_start = 1'b0;
        dump_start  = 1'b0;
        begin
            int saw = 0;
            int guard = 0;
            out_ready = 1'b1;
            while (busy && guard < 2000) begin
                #1;
                if (out_valid) saw = 1;
                if (guard == 5) dump_start = 1'b1;
                if (guard == 6) dump_start = 1'b0;
                @(negedge clk);
                guard++;
            end
            repeat (5) begin
                @(negedge clk);
                #1;
                if (out_valid || busy) saw = 1;
            end
            out_ready = 1'b0;
            check("R9", "no readout word during combined command", saw, 0);
        end
        model_zero();
        run_dump("R9 clear won", 1'b0);
        check("R8", "drop_count sticky", int'(drop_count), DMAX);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule